// File: doc/BRIEF.md
# Soft Mute Ramp and Zero-Run Detector

This block sits in the stereo sample path just ahead of a DAC. It runs on a fast system clock and acts once per audio frame, on a one-cycle frame strobe. When a mute request is raised, the gain applied to both channels falls linearly to zero over 1024 frames. When the request is dropped, the gain climbs back to unity over the same span. A request that changes mid-ramp turns the ramp around from the gain it has reached. Each sample is multiplied by the gain and rounded, and the result can never overflow the 24-bit output.

The block also counts, per channel, the run of consecutive zero-valued samples. A zero flag rises once both channels have seen 8192 zeros in a row. The flag is gated by a detect enable. An active-low channel reset forces the flag high, and keeps it high for a few frames after the reset is released.

Top module: `dac_mute_zero`

## Requirements
- R1: After system reset both outputs read 0, the zero flag is low and the gain is unity (1024/1024).
- R2: At unity gain each strobed frame copies the input samples unchanged to the outputs on the next clock edge. Between strobes the outputs hold their values.
- R3: With the mute request high, each frame strobe lowers the gain by 1/1024 until it reaches 0. A full-scale input therefore reads exactly 0 from the 1025th strobed frame onward.
- R4: With the mute request low, each frame strobe raises the gain by 1/1024 until it reaches unity, so the output again equals the input.
- R5: When the request changes mid-ramp, the gain reverses from its current value. It never changes by more than one step per frame, and it never changes without a strobe.
- R6: Each output equals floor((sample × gain + 512) / 1024), with samples in 24-bit two's complement and gain in 0..1024. The output never changes sign and never exceeds the input's magnitude.
- R7: A channel's zero run counts consecutive strobed frames whose sample is 0 and saturates at 8192. The flag rises on the clock edge of the frame that completes the run on both channels, and not one frame earlier.
- R8: A nonzero sample on either channel clears that channel's run, and the flag falls on the same clock edge.
- R9: The flag needs both channels to be saturated. A run completed on one channel alone leaves the flag low.
- R10: With the detect enable low, the flag is low unless it is held by R11. Raising the enable over saturated runs sets the flag without waiting for another frame.
- R11: While the channel reset is low, the flag is high from the next clock edge and both zero runs are cleared. After release the flag stays high for 6 more strobed frames and then follows R7 to R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStb | input | 1 | One-cycle strobe per audio frame |
| muteReq | input | 1 | Soft-mute request, 1 = ramp to silence |
| detEn | input | 1 | Zero-detect enable |
| chanRstN | input | 1 | Active-low channel reset, forces the flag high |
| leftIn | input | 24 | Left sample, two's complement |
| rightIn | input | 24 | Right sample, two's complement |
| leftOut | output | 24 | Scaled left sample |
| rightOut | output | 24 | Scaled right sample |
| zeroFlag | output | 1 | Both channels idle with zeros |

## Verification
A wrong gain register shows up on the next strobed frame of any nonzero sample as an output that is off from the rounded product. Driving full-scale samples through a whole ramp exposes a wrong step, a wrong end point or a jump at a reversal within one frame. A miscounted zero run only becomes visible at the threshold boundary. The bench therefore checks the frame just before the 8192nd zero as well as that frame itself, and also checks the release hold frame by frame. A bad flag gating term shows within one clock of the matching enable, reset or nonzero-sample change.

// File: rtl/smz_pkg.sv
package smz_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // a frame is being taken this cycle
    logic hold;   // channel reset active: clear zero runs
  } smz_strobe_t;
endpackage

// File: rtl/smz_scale.sv
module smz_scale #(
  parameter int DW = 24,
  parameter int RAMP_LOG2 = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 load,
  input  logic [RAMP_LOG2:0]   gain,
  input  logic [DW-1:0]        sample,
  output logic [DW-1:0]        scaled
);
  localparam int GW = RAMP_LOG2 + 1;
  localparam int PW = DW + GW + 1;

  logic signed [PW-1:0] product;
  logic signed [PW-1:0] rounded;
  logic signed [PW-1:0] shifted;

  always_comb begin
    product = PW'($signed(sample)) * PW'($signed({1'b0, gain}));
    rounded = product + (PW'(1) <<< (RAMP_LOG2 - 1));
    shifted = rounded >>> RAMP_LOG2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) scaled <= '0;
    else if (load) scaled <= shifted[DW-1:0];
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    load && !sample[DW-1] |=> !scaled[DW-1]);
  // R3
  silent_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    load && gain == '0 |=> scaled == '0);
endmodule

// File: rtl/smz_zero_run.sv
module smz_zero_run #(
  parameter int DW = 24,
  parameter int ZERO_RUN = 8192
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          hold,
  input  logic [DW-1:0] sample,
  output logic          runDone
);
  localparam int CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] THR = CW'(ZERO_RUN);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN || hold) runCnt <= '0;
    else if (load) begin
      if (sample != '0) runCnt <= '0;
      else if (runCnt != THR) runCnt <= runCnt + 1'b1;
    end
  end

  assign runDone = (runCnt == THR);

  // R7
  run_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= THR);
  // R8
  run_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    load && sample != '0 |=> !runDone);
endmodule

// File: rtl/smz_datapath.sv
module smz_datapath
  import smz_pkg::*;
#(
  parameter int DW = 24,
  parameter int RAMP_LOG2 = 10,
  parameter int ZERO_RUN = 8192
) (
  input  logic               clk,
  input  logic               rstN,
  input  smz_strobe_t        stb,
  input  logic [RAMP_LOG2:0] gain,
  input  logic [DW-1:0]      leftIn,
  input  logic [DW-1:0]      rightIn,
  output logic [DW-1:0]      leftOut,
  output logic [DW-1:0]      rightOut,
  output logic               bothRun
);
  localparam int NCH = 2;

  logic [DW-1:0] chIn  [NCH];
  logic [DW-1:0] chOut [NCH];
  logic [NCH-1:0] chRun;

  assign chIn[0] = leftIn;
  assign chIn[1] = rightIn;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    smz_scale #(.DW(DW), .RAMP_LOG2(RAMP_LOG2)) i_scale (
      .clk(clk), .rstN(rstN), .load(stb.load), .gain(gain),
      .sample(chIn[ch]), .scaled(chOut[ch])
    );
    smz_zero_run #(.DW(DW), .ZERO_RUN(ZERO_RUN)) i_run (
      .clk(clk), .rstN(rstN), .load(stb.load), .hold(stb.hold),
      .sample(chIn[ch]), .runDone(chRun[ch])
    );
  end

  assign leftOut  = chOut[0];
  assign rightOut = chOut[1];
  assign bothRun  = &chRun;
endmodule

// File: rtl/smz_control.sv
module smz_control
  import smz_pkg::*;
#(
  parameter int RAMP_LOG2 = 10,
  parameter int REL_HOLD = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStb,
  input  logic               muteReq,
  input  logic               detEn,
  input  logic               chanRstN,
  input  logic               bothRun,
  output smz_strobe_t        stb,
  output logic [RAMP_LOG2:0] gain,
  output logic               zeroFlag
);
  localparam int GW = RAMP_LOG2 + 1;
  localparam logic [GW-1:0] UNITY = GW'(1) << RAMP_LOG2;
  localparam int HW = $clog2(REL_HOLD + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(REL_HOLD);

  logic [HW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) gain <= UNITY;
    else if (frameStb) begin
      if (muteReq) begin
        if (gain != '0) gain <= gain - 1'b1;
      end else if (gain != UNITY) gain <= gain + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdCnt <= '0;
    else if (!chanRstN) holdCnt <= HOLD_INIT;
    else if (frameStb && holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign stb.load = frameStb;
  assign stb.hold = !chanRstN;
  assign zeroFlag = (holdCnt != '0) || (detEn && bothRun);

  // R3
  mute_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStb && muteReq && gain != '0 |=> gain == $past(gain) - 1'b1);
  // R4
  rise_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStb && !muteReq && gain != UNITY |=> gain == $past(gain) + 1'b1);
  // R5
  gain_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStb |=> $stable(gain));
  // R11
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanRstN |=> zeroFlag);
endmodule

// File: rtl/dac_mute_zero.sv
module dac_mute_zero
  import smz_pkg::*;
#(
  parameter int DW = 24,
  parameter int RAMP_LOG2 = 10,
  parameter int ZERO_RUN = 8192,
  parameter int REL_HOLD = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStb,
  input  logic          muteReq,
  input  logic          detEn,
  input  logic          chanRstN,
  input  logic [DW-1:0] leftIn,
  input  logic [DW-1:0] rightIn,
  output logic [DW-1:0] leftOut,
  output logic [DW-1:0] rightOut,
  output logic          zeroFlag
);
  smz_strobe_t        stb;
  logic [RAMP_LOG2:0] gain;
  logic               bothRun;

  smz_control #(.RAMP_LOG2(RAMP_LOG2), .REL_HOLD(REL_HOLD)) i_control (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .muteReq(muteReq),
    .detEn(detEn), .chanRstN(chanRstN), .bothRun(bothRun),
    .stb(stb), .gain(gain), .zeroFlag(zeroFlag)
  );

  smz_datapath #(.DW(DW), .RAMP_LOG2(RAMP_LOG2), .ZERO_RUN(ZERO_RUN)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .gain(gain),
    .leftIn(leftIn), .rightIn(rightIn),
    .leftOut(leftOut), .rightOut(rightOut), .bothRun(bothRun)
  );
endmodule

// File: tb/test_dac_mute_zero.sv
`timescale 1ns/1ps
module test_dac_mute_zero;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 1'b0;
  logic muteReq = 1'b0;
  logic detEn = 1'b0;
  logic chanRstN = 1'b1;
  logic [23:0] leftIn = '0;
  logic [23:0] rightIn = '0;
  logic [23:0] leftOut, rightOut;
  logic zeroFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  int mGain = 1024;
  int mCntL = 0, mCntR = 0, mHold = 0;
  logic [23:0] mOutL = '0, mOutR = '0;

  always #2.5 clk = ~clk;

  dac_mute_zero i_dac_mute_zero (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .muteReq(muteReq),
    .detEn(detEn), .chanRstN(chanRstN), .leftIn(leftIn), .rightIn(rightIn),
    .leftOut(leftOut), .rightOut(rightOut), .zeroFlag(zeroFlag)
  );

  function automatic logic [23:0] scaleRef(logic [23:0] s, int g);
    longint p;
    p = longint'($signed(s)) * g + 512;
    p = p >>> 10;
    return p[23:0];
  endfunction

  function automatic bit flagRef();
    return (mHold != 0) || (detEn && mCntL == 8192 && mCntR == 8192);
  endfunction

  task automatic compare();
    bit ef;
    ef = flagRef();
    checks++;
    if (leftOut !== mOutL || rightOut !== mOutR || zeroFlag !== ef) begin
      errors++;
      $display("FAIL %s: out L=%h R=%h flag=%b expected L=%h R=%h flag=%b",
               curReq, leftOut, rightOut, zeroFlag, mOutL, mOutR, ef);
    end
  endtask

  task automatic namedCheck(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: inputs already driven at negedge
  task automatic step(bit stb, logic [23:0] l, logic [23:0] r);
    frameStb = stb; leftIn = l; rightIn = r;
    @(posedge clk);
    if (rstN) begin
      if (!chanRstN) begin
        mHold = 6; mCntL = 0; mCntR = 0;
      end else if (stb) begin
        if (mHold > 0) mHold--;
        mCntL = (l != 0) ? 0 : ((mCntL < 8192) ? mCntL + 1 : 8192);
        mCntR = (r != 0) ? 0 : ((mCntR < 8192) ? mCntR + 1 : 8192);
      end
      if (stb) begin
        mOutL = scaleRef(l, mGain);
        mOutR = scaleRef(r, mGain);
        if (muteReq) begin
          if (mGain > 0) mGain--;
        end else if (mGain < 1024) mGain++;
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic frames(int n, logic [23:0] l, logic [23:0] r);
    for (int i = 0; i < n; i++) step(1'b1, l, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    curReq = "R1";
    compare();
    rstN = 1'b1;
    step(1'b0, 24'h123456, 24'h654321);
    namedCheck("R1", leftOut, 24'h0);
    namedCheck("R1", {23'b0, zeroFlag}, 24'h0);

    // R2 pass-through at unity
    curReq = "R2";
    step(1'b1, 24'h7FFFFF, 24'h800000);
    namedCheck("R2", leftOut, 24'h7FFFFF);
    namedCheck("R2", rightOut, 24'h800000);
    for (int i = 0; i < 60; i++) step(i % 3 != 2, 24'($urandom), 24'($urandom));
    step(1'b0, 24'h000111, 24'h000222);

    // R3 ramp down with full-scale inputs
    curReq = "R3";
    muteReq = 1'b1;
    for (int i = 0; i < 1100; i++)
      step(1'b1, (i % 2) ? 24'h7FFFFF : 24'h800000, (i % 2) ? 24'h800000 : 24'h7FFFFF);
    namedCheck("R3", leftOut, 24'h0);
    namedCheck("R3", rightOut, 24'h0);

    // R4 ramp back up
    curReq = "R4";
    muteReq = 1'b0;
    for (int i = 0; i < 1100; i++) step(1'b1, 24'h400001, 24'hC00003);
    namedCheck("R4", leftOut, 24'h400001);

    // R5 reversal mid-ramp, with gaps between strobes
    curReq = "R5";
    muteReq = 1'b1;
    for (int i = 0; i < 300; i++) step(i % 2 == 0, 24'h7FFFFF, 24'h800000);
    muteReq = 1'b0;
    for (int i = 0; i < 200; i++) step(1'b1, 24'h7FFFFF, 24'h800000);
    muteReq = 1'b1;
    for (int i = 0; i < 100; i++) step(1'b1, 24'h7FFFFF, 24'h800000);

    // R6 rounding at intermediate gains with mixed values
    curReq = "R6";
    for (int i = 0; i < 400; i++) step(1'b1, 24'($urandom), 24'($urandom));
    muteReq = 1'b0;
    for (int i = 0; i < 1100; i++) step(1'b1, 24'($urandom), 24'($urandom));

    // R7 zero run threshold
    curReq = "R7";
    detEn = 1'b1;
    frames(8191, 24'h0, 24'h0);
    namedCheck("R7", {23'b0, zeroFlag}, 24'h0);
    step(1'b1, 24'h0, 24'h0);
    namedCheck("R7", {23'b0, zeroFlag}, 24'h1);
    frames(20, 24'h0, 24'h0);

    // R8 nonzero sample clears the flag on the same edge
    curReq = "R8";
    step(1'b1, 24'h0, 24'h000001);
    namedCheck("R8", {23'b0, zeroFlag}, 24'h0);

    // R9 only left saturated: flag stays low
    curReq = "R9";
    frames(8300, 24'h0, 24'hFFFFFF);
    namedCheck("R9", {23'b0, zeroFlag}, 24'h0);
    frames(8192, 24'h0, 24'h0);
    namedCheck("R9", {23'b0, zeroFlag}, 24'h1);

    // R10 enable gating
    curReq = "R10";
    detEn = 1'b0;
    step(1'b0, 24'h0, 24'h0);
    namedCheck("R10", {23'b0, zeroFlag}, 24'h0);
    frames(5, 24'h0, 24'h0);
    detEn = 1'b1;
    step(1'b0, 24'h0, 24'h0);
    namedCheck("R10", {23'b0, zeroFlag}, 24'h1);

    // R11 channel reset forces the flag, then holds it after release
    curReq = "R11";
    detEn = 1'b0;
    step(1'b1, 24'h000005, 24'h0);
    chanRstN = 1'b0;
    step(1'b0, 24'h000005, 24'h0);
    namedCheck("R11", {23'b0, zeroFlag}, 24'h1);
    step(1'b1, 24'h000005, 24'h0);
    chanRstN = 1'b1;
    frames(5, 24'h000005, 24'h0);
    namedCheck("R11", {23'b0, zeroFlag}, 24'h1);
    step(1'b1, 24'h000005, 24'h0);
    namedCheck("R11", {23'b0, zeroFlag}, 24'h0);
    detEn = 1'b1;
    chanRstN = 1'b0;
    frames(3, 24'h0, 24'h0);
    chanRstN = 1'b1;
    frames(8200, 24'h0, 24'h0);
    namedCheck("R11", {23'b0, zeroFlag}, 24'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule